// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block is the enhanced-mode access path of a printer port controller. The host reaches it through a simple request interface. It sees only three offsets: the address-strobe register at offset 3, the data-strobe register at offset 4 and the status offset at offset 1. The plain data, status and control registers live in a neighbouring block. That block supplies the current control byte and the external status byte as inputs.

An access to offset 3 or 4 first passes a legality gate on the control byte. A write needs one control pattern and a read needs another. A legal access runs one or more byte transfers on a request/acknowledge peripheral interface. Data accesses may be 8, 16 or 32 bits wide and move their bytes least significant first. Address accesses always move one byte.

A byte that gets no acknowledge within a bounded wait counts as a failure. The failure ends the access and sets a sticky timeout flag. The host sees that flag as bit 0 of the status byte and clears it by writing a 1 to that bit.

Top module: `epp_gate`

## Requirements
- R1: A write to offset 3 or 4 starts peripheral transfers only when (ctrl_reg & 0x2F) == 0x04. Otherwise no transfer occurs, the timeout flag is unchanged, and the response returns all-ones data.
- R2: A read from offset 3 or 4 starts peripheral transfers only when (ctrl_reg & 0x2F) == 0x24. Otherwise no transfer occurs and host_rdata is 0xFFFFFFFF.
- R3: Offset 3 moves exactly one byte with per_is_addr=1. Offset 4 moves bytes with per_is_addr=0. per_write equals the host direction.
- R4: At offset 4, host_size 0 moves 1 byte, 1 moves 2 bytes, and 2 or 3 move 4 bytes. Byte i is host_wdata[8i+7:8i] (or lands in host_rdata[8i+7:8i]), starting at i=0. Read lanes beyond the size read as 0xFF.
- R5: per_req stays high for each byte until per_ack is sampled. A byte with no acknowledge fails after exactly TIMEOUT_CYC cycles of request.
- R6: A failed byte sets the timeout flag. The flag stays set across later accesses until it is cleared.
- R7: A write to offset 1 with host_wdata[0]=1 clears the timeout flag. With bit 0 clear the flag is unchanged.
- R8: A read of offset 1 returns {24'hFFFFFF, ext_status[7:1], timeout flag}.
- R9: A multi-byte access stops at the first failed byte. No later byte is requested, and every read lane from the failed byte upward is 0xFF.
- R10: host_busy is high from the cycle after a legal transfer is accepted until its response. host_rsp_valid pulses once per accepted access. Requests presented while busy are ignored.
- R11: After reset, host_busy and per_req are low and the timeout flag is clear.
- R12: Accesses to offsets other than 1, 3 and 4 respond with all-ones data and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access request, taken when not busy |
| host_write | input | 1 | 1 = write, 0 = read |
| host_offset | input | 3 | Register offset |
| host_size | input | 2 | Access width code (0: 8, 1: 16, 2/3: 32 bits) |
| host_wdata | input | 32 | Write data |
| host_busy | output | 1 | Multi-byte access in progress |
| host_rsp_valid | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_rsp_valid |
| ctrl_reg | input | 8 | Current control byte from the neighbouring block |
| ext_status | input | 8 | External status byte |
| per_req | output | 1 | Peripheral byte request |
| per_write | output | 1 | Peripheral transfer direction (1 = write) |
| per_is_addr | output | 1 | 1 = address strobe, 0 = data strobe |
| per_wdata | output | 8 | Byte sent to the peripheral |
| per_rdata | input | 8 | Byte returned by the peripheral |
| per_ack | input | 1 | Peripheral acknowledge for the current byte |

## Verification
Several properties are checked on every cycle. A request is held until it is acknowledged or its wait ends, and the wait never exceeds its bound. A request only appears while the host sees busy. A gated-off access never raises a request. The timeout flag only rises after a byte failure and only falls after a host clear write. The bench scenarios cover what the properties cannot see. These are the byte order across lanes, all-ones filling of the lanes a failure left untransferred, the exact count of bytes reaching the peripheral, the status byte with its substituted bit, and the flag surviving a clear attempt made while the block is busy.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam logic [7:0] CTRL_MASK  = 8'h2F;
  localparam logic [7:0] WR_PATTERN = 8'h04;
  localparam logic [7:0] RD_PATTERN = 8'h24;
  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_ADDR   = 3'd3;
  localparam logic [2:0] OFS_DATA   = 3'd4;

  typedef enum logic {GATE_IDLE, GATE_RUN} gate_state_t;

  // control byte legality for an enhanced cycle of the given direction
  function automatic logic cycle_allowed(input logic [7:0] ctrl, input logic is_wr);
    return (ctrl & CTRL_MASK) == (is_wr ? WR_PATTERN : RD_PATTERN);
  endfunction

  // index of the last byte of an access
  function automatic logic [1:0] last_lane(input logic [2:0] ofs, input logic [1:0] sz);
    if (ofs == OFS_ADDR) return 2'd0;
    case (sz)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [31:0] lane_put(input logic [31:0] word, input logic [1:0] idx,
                                           input logic [7:0] b);
    logic [31:0] w;
    w = word;
    w[idx*8 +: 8] = b;
    return w;
  endfunction
endpackage

// File: rtl/epp_cycle_check.sv
module epp_cycle_check
  import epp_gate_pkg::*;
(
  input  logic [7:0] ctrl,
  input  logic [2:0] offset,
  input  logic       is_write,
  output logic       is_epp,
  output logic       allowed
);
  always_comb begin
    is_epp  = (offset == OFS_ADDR) || (offset == OFS_DATA);
    allowed = is_epp && cycle_allowed(ctrl, is_write);
  end
endmodule

// File: rtl/epp_byte_engine.sv
module epp_byte_engine #(
  parameter int TIMEOUT_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_write,
  input  logic       is_addr,
  input  logic [7:0] wbyte,
  output logic       per_req,
  output logic       per_write,
  output logic       per_is_addr,
  output logic [7:0] per_wdata,
  input  logic       per_ack,
  input  logic [7:0] per_rdata,
  output logic       byte_ok,
  output logic       byte_fail,
  output logic [7:0] rbyte
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC - 1);

  logic          active;
  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      wait_cnt    <= '0;
      per_write   <= 1'b0;
      per_is_addr <= 1'b0;
      per_wdata   <= 8'h00;
    end else if (start) begin
      active      <= 1'b1;
      wait_cnt    <= '0;
      per_write   <= is_write;
      per_is_addr <= is_addr;
      per_wdata   <= wbyte;
    end else if (active) begin
      if (per_ack || wait_cnt == LIM) active <= 1'b0;
      else wait_cnt <= wait_cnt + 1'b1;
    end
  end

  always_comb begin
    per_req   = active;
    byte_ok   = active && per_ack;
    byte_fail = active && !per_ack && (wait_cnt == LIM);
    rbyte     = per_rdata;
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_req && !per_ack && !byte_fail && !start) |=> per_req);
  // R5
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (wait_cnt <= LIM));
  // R5
  fail_ends_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fail && !start) |=> !per_req);
endmodule

// File: rtl/epp_gate.sv
module epp_gate
  import epp_gate_pkg::*;
#(
  parameter int TIMEOUT_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  input  logic        host_write,
  input  logic [2:0]  host_offset,
  input  logic [1:0]  host_size,
  input  logic [31:0] host_wdata,
  output logic        host_busy,
  output logic        host_rsp_valid,
  output logic [31:0] host_rdata,
  input  logic [7:0]  ctrl_reg,
  input  logic [7:0]  ext_status,
  output logic        per_req,
  output logic        per_write,
  output logic        per_is_addr,
  output logic [7:0]  per_wdata,
  input  logic [7:0]  per_rdata,
  input  logic        per_ack
);
  localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;

  gate_state_t state;
  logic        kick, write_q, addr_q, tmo_flag;
  logic [1:0]  idx, last_idx;
  logic [31:0] wdata_q, rdata_q, rdata_next;
  logic        accept, is_epp, allowed;
  logic        byte_ok, byte_fail, byte_done;
  logic [7:0]  rbyte;

  epp_cycle_check u_check (
    .ctrl(ctrl_reg), .offset(host_offset), .is_write(host_write),
    .is_epp(is_epp), .allowed(allowed)
  );

  epp_byte_engine #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(kick), .is_write(write_q), .is_addr(addr_q),
    .wbyte(wdata_q[idx*8 +: 8]),
    .per_req(per_req), .per_write(per_write), .per_is_addr(per_is_addr),
    .per_wdata(per_wdata), .per_ack(per_ack), .per_rdata(per_rdata),
    .byte_ok(byte_ok), .byte_fail(byte_fail), .rbyte(rbyte)
  );

  always_comb begin
    accept     = host_valid && (state == GATE_IDLE);
    byte_done  = byte_ok || byte_fail;
    rdata_next = byte_ok ? lane_put(rdata_q, idx, rbyte) : rdata_q;
    host_busy  = (state == GATE_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= GATE_IDLE;
      kick           <= 1'b0;
      write_q        <= 1'b0;
      addr_q         <= 1'b0;
      tmo_flag       <= 1'b0;
      idx            <= 2'd0;
      last_idx       <= 2'd0;
      wdata_q        <= '0;
      rdata_q        <= ALL_ONES;
      host_rsp_valid <= 1'b0;
      host_rdata     <= ALL_ONES;
    end else begin
      kick           <= 1'b0;
      host_rsp_valid <= 1'b0;
      if (byte_fail) tmo_flag <= 1'b1;
      if (accept) begin
        if (allowed) begin
          state    <= GATE_RUN;
          kick     <= 1'b1;
          idx      <= 2'd0;
          last_idx <= last_lane(host_offset, host_size);
          write_q  <= host_write;
          addr_q   <= (host_offset == OFS_ADDR);
          wdata_q  <= host_wdata;
          rdata_q  <= ALL_ONES;
        end else begin
          host_rsp_valid <= 1'b1;
          host_rdata     <= ALL_ONES;
          if (host_offset == OFS_STATUS) begin
            if (host_write && host_wdata[0]) tmo_flag <= 1'b0;
            if (!host_write) host_rdata <= {24'hFF_FFFF, ext_status[7:1], tmo_flag};
          end
        end
      end else if (state == GATE_RUN && byte_done) begin
        rdata_q <= rdata_next;
        if (byte_ok && idx != last_idx) begin
          idx  <= idx + 2'd1;
          kick <= 1'b1;
        end else begin
          state          <= GATE_IDLE;
          host_rsp_valid <= 1'b1;
          host_rdata     <= write_q ? ALL_ONES : rdata_next;
        end
      end
    end
  end

  // R6
  tmo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(byte_fail));
  // R7
  tmo_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo_flag) |-> $past(accept && host_write && host_offset == OFS_STATUS && host_wdata[0]));
  // R1
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_epp && !allowed) |=> !per_req);
  // R10
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_req |-> host_busy);
  // R9
  fail_finishes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fail |=> (host_rsp_valid && !host_busy));
endmodule

// File: tb/tb_epp_gate.sv
`timescale 1ns/1ps
module tb_epp_gate;
  localparam int TMO = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [2:0]  host_offset = 3'd0;
  logic [1:0]  host_size = 2'd0;
  logic [31:0] host_wdata = '0;
  logic        host_busy, host_rsp_valid;
  logic [31:0] host_rdata;
  logic [7:0]  ctrl_reg = 8'h00, ext_status = 8'h00;
  logic        per_req, per_write, per_is_addr;
  logic [7:0]  per_wdata;
  logic [7:0]  per_rdata = 8'h00;
  logic        per_ack = 1'b0;

  int checks = 0, errors = 0;

  // peripheral model state
  int fail_at = 4, dly = 0, cnt = 0, bidx = 0, req_cycles = 0, fail_req_cycles = 0;
  logic [7:0] rx [4];
  logic       rx_addr, rx_write;
  logic [7:0] rd_base = 8'h30;
  logic       tmo_exp = 1'b0;

  always #10 clk = ~clk;

  epp_gate #(.TIMEOUT_CYC(TMO)) dut (.*);

  function automatic logic [7:0] model_byte(input int b);
    return rd_base + 8'(b * 8'h11);
  endfunction

  function automatic int bytes_of(input logic [2:0] ofs, input logic [1:0] sz);
    if (ofs == 3'd3) return 1;
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic legal(input logic [7:0] c, input logic wr);
    return wr ? ((c & 8'h2F) == 8'h04) : ((c & 8'h2F) == 8'h24);
  endfunction

  always @(negedge clk) begin
    if (per_ack) per_ack = 1'b0;
    else if (per_req) begin
      req_cycles++;
      if (bidx == fail_at) fail_req_cycles++;
      else if (cnt >= dly) begin
        per_ack   = 1'b1;
        per_rdata = model_byte(bidx);
        if (bidx < 4) rx[bidx] = per_wdata;
        rx_addr  = per_is_addr;
        rx_write = per_write;
        bidx++;
        cnt = 0;
      end else cnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic prep(input int f, input int d);
    fail_at = f; dly = d; cnt = 0; bidx = 0; req_cycles = 0; fail_req_cycles = 0;
  endtask

  task automatic issue(input logic wr, input logic [2:0] ofs, input logic [1:0] sz,
                       input logic [31:0] wd);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_offset = ofs; host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic wait_rsp(output logic [31:0] rd);
    for (int i = 0; i < 400 && !host_rsp_valid; i++) @(negedge clk);
    rd = host_rdata;
    @(negedge clk);
  endtask

  // full access with expectation checks for offsets 3 and 4
  task automatic epp_access(input logic wr, input logic [2:0] ofs, input logic [1:0] sz,
                            input logic [31:0] wd, input int f, input int d);
    logic [31:0] rd, exp;
    int nb, done;
    logic ok;
    prep(f, d);
    nb = bytes_of(ofs, sz);
    ok = legal(ctrl_reg, wr);
    issue(wr, ofs, sz, wd);
    if (ok) check("R10 busy after accept", 32'(host_busy), 32'd1);
    wait_rsp(rd);
    if (!ok) begin
      check(wr ? "R1 gated write no bytes" : "R2 gated read no bytes", 32'(req_cycles), 32'd0);
      check("R2 gated data all ones", rd, 32'hFFFF_FFFF);
      return;
    end
    done = (f < nb) ? f : nb;
    if (f < nb) begin
      tmo_exp = 1'b1;
      check("R5 failed byte request length", 32'(fail_req_cycles), 32'(TMO));
    end
    check("R9 bytes transferred", 32'(bidx), 32'(done));
    check("R3 strobe select", 32'(rx_addr), (done > 0) ? 32'(ofs == 3'd3) : 32'(rx_addr));
    if (done > 0) check("R3 direction", 32'(rx_write), 32'(wr));
    exp = 32'hFFFF_FFFF;
    for (int i = 0; i < done; i++) begin
      if (wr) check("R4 write byte order", 32'(rx[i]), 32'(wd[i*8 +: 8]));
      else exp[i*8 +: 8] = model_byte(i);
    end
    check(wr ? "R1 write response" : "R4 R9 read lanes", rd, exp);
    check("R10 idle after response", 32'(host_busy), 32'd0);
  endtask

  task automatic status_read_chk(input string req);
    logic [31:0] rd;
    issue(1'b0, 3'd1, 2'd0, 32'h0);
    wait_rsp(rd);
    check(req, rd, {24'hFF_FFFF, ext_status[7:1], tmo_exp});
  endtask

  task automatic status_write(input logic [31:0] wd);
    logic [31:0] rd;
    issue(1'b1, 3'd1, 2'd0, wd);
    wait_rsp(rd);
    if (wd[0]) tmo_exp = 1'b0;
  endtask

  initial begin
    #(20ns * 180000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    ext_status = 8'hA7;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 busy at reset", 32'(host_busy), 32'd0);
    check("R11 req at reset", 32'(per_req), 32'd0);
    rst_n = 1'b1;
    status_read_chk("R11 R8 flag clear after reset");

    // directed legal cases
    ctrl_reg = 8'hC4;
    epp_access(1'b1, 3'd3, 2'd2, 32'h1122_3344, 4, 1);
    epp_access(1'b1, 3'd4, 2'd1, 32'hAABB_CCDD, 4, 0);
    epp_access(1'b1, 3'd4, 2'd2, 32'h0102_0304, 4, 3);
    ctrl_reg = 8'h24;
    epp_access(1'b0, 3'd4, 2'd0, 32'h0, 4, 2);
    epp_access(1'b0, 3'd4, 2'd3, 32'h0, 4, 0);
    epp_access(1'b0, 3'd3, 2'd2, 32'h0, 4, 1);
    // gating corner: one bit off the pattern
    ctrl_reg = 8'h25;
    epp_access(1'b0, 3'd4, 2'd2, 32'h0, 4, 0);
    ctrl_reg = 8'h24;
    epp_access(1'b1, 3'd4, 2'd2, 32'h5555_5555, 4, 0);
    ctrl_reg = 8'hD0;
    epp_access(1'b1, 3'd3, 2'd0, 32'h77, 4, 0);
    // R9 failure in middle of a 4-byte read
    ctrl_reg = 8'h24;
    epp_access(1'b0, 3'd4, 2'd2, 32'h0, 2, 1);
    status_read_chk("R6 flag set after failure");
    // R7 write with bit 0 clear does not clear
    status_write(32'hFFFF_FFFE);
    status_read_chk("R7 clear needs bit 0");
    // R10 request ignored while busy, flag kept
    ctrl_reg = 8'h04;
    prep(4, 3);
    issue(1'b1, 3'd4, 2'd2, 32'hDEAD_BEEF);
    issue(1'b1, 3'd1, 2'd0, 32'h1);
    wait_rsp(rd);
    check("R10 busy request ignored bytes", 32'(bidx), 32'd4);
    status_read_chk("R10 clear while busy ignored");
    status_write(32'h1);
    status_read_chk("R7 flag cleared");
    // R12 other offsets
    prep(4, 0);
    issue(1'b1, 3'd6, 2'd2, 32'h0000_0001);
    wait_rsp(rd);
    check("R12 other offset data", rd, 32'hFFFF_FFFF);
    check("R12 other offset no bytes", 32'(req_cycles), 32'd0);
    ctrl_reg = 8'h24;
    epp_access(1'b0, 3'd4, 2'd0, 32'h0, 0, 0);
    issue(1'b0, 3'd2, 2'd0, 32'h0);
    wait_rsp(rd);
    check("R12 other offset read", rd, 32'hFFFF_FFFF);
    status_read_chk("R12 flag untouched by other offsets");

    // constrained random
    for (int n = 0; n < 300; n++) begin
      int sel, f;
      logic wr;
      logic [2:0] ofs;
      sel = $urandom_range(0, 3);
      ctrl_reg = (sel == 0) ? 8'h04 : (sel == 1) ? 8'h24 : 8'($urandom);
      if ($urandom_range(0, 1) == 1) ctrl_reg = ctrl_reg | 8'hC0;
      ext_status = 8'($urandom);
      rd_base = 8'($urandom);
      wr = 1'($urandom);
      sel = $urandom_range(0, 9);
      if (sel == 0) begin
        if (wr) status_write({31'($urandom), 1'($urandom)});
        else status_read_chk("R8 status random");
      end else begin
        ofs = (sel < 4) ? 3'd3 : 3'd4;
        f = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 3) : 4;
        epp_access(wr, ofs, 2'($urandom), $urandom, f, $urandom_range(0, 3));
      end
    end
    status_read_chk("R6 R8 final flag");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule